// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block lets two agents sharing a memory signal each other without polling. It observes the accesses of two ports, called left and right, on a 14-bit word address space. The two highest word addresses are mailboxes: the top word belongs to the right port and the word below it belongs to the left port. When one port stores a word into the other port's mailbox, the owner's interrupt output goes low. The owner reads its mailbox to take the message, and that read releases its interrupt.

Each port has a busy input. While busy is high, the port's mailbox write cannot raise the other side's interrupt, and its read of its own mailbox cannot release its own interrupt. The two mailbox words are held in registers inside the block, so message passing can be exercised without an attached memory array. All enables are active high. Flag and mailbox updates occur on the rising clock edge. Read data is combinational from the current address and controls.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both interrupt outputs are high and both mailbox words read back as zero.
- R2: A left write (ce and we high) to address 0x3FFF with left busy low drives r_irq_n low from the next cycle. A right write to 0x3FFE with right busy low drives l_irq_n low in the same way.
- R3: A read (ce and oe high, we low) by the right port of 0x3FFF with right busy low returns r_irq_n high from the next cycle. A left read of 0x3FFE with left busy low does the same for l_irq_n.
- R4: A port reading the other port's mailbox changes neither interrupt output.
- R5: A mailbox write from a port whose busy is high leaves the target interrupt unchanged, although the data word is still stored.
- R6: A read of its own mailbox by a port whose busy is high leaves that port's interrupt low.
- R7: When a setting write and a clearing read hit the same flag in one cycle, the flag is low after the edge.
- R8: A write to either mailbox address by either port stores wdata on the edge, regardless of busy. A read of a mailbox address returns the stored word in the same cycle. If both ports write the same mailbox in one cycle, the non-owner's data is kept.
- R9: rdata is zero when the port is not reading (ce or oe low, or we high) or when it reads any address other than the two mailboxes. Such accesses leave both flags unchanged.
- R10: A port writing its own mailbox stores the word but changes neither interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce | input | 1 | Left port chip enable |
| l_oe | input | 1 | Left port read enable |
| l_we | input | 1 | Left port write strobe |
| l_busy | input | 1 | Left port veto of interrupt set and clear |
| l_addr | input | 14 | Left port word address |
| l_wdata | input | 16 | Left port write data |
| l_rdata | output | 16 | Left port mailbox read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_ce | input | 1 | Right port chip enable |
| r_oe | input | 1 | Right port read enable |
| r_we | input | 1 | Right port write strobe |
| r_busy | input | 1 | Right port veto of interrupt set and clear |
| r_addr | input | 14 | Right port word address |
| r_wdata | input | 16 | Right port write data |
| r_rdata | output | 16 | Right port mailbox read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bound checker checks the flag rules on every cycle. An unvetoed setting write always pulls the target flag low. An unvetoed owner read releases the flag unless a set collides with it. A high flag stays high without an unvetoed set, and a low flag stays low without an unvetoed clear. It also checks that idle or non-mailbox reads return zero, and that both ports agree when reading the same mailbox. Only the bench scenarios can show that stored words match what was written, including the non-owner priority on a double write, and that busy blocks the flag while still letting the data through. An exhaustive sweep of both ports' control, busy and address classes compares every output against a model built from the requirements.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int NPORT = 2;

   typedef struct packed {
      logic rd_own;
      logic rd_peer;
      logic wr_own;
      logic wr_peer;
   } port_evt_t;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
   parameter int ADDR_W = 14,
   parameter logic [ADDR_W-1:0] OWN_ADDR  = '0,
   parameter logic [ADDR_W-1:0] PEER_ADDR = '0
) (
   input  logic              ce,
   input  logic              oe,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output mbx_pkg::port_evt_t evt
);
   logic rd, wr, hit_own, hit_peer;

   always_comb begin
      rd          = ce & oe & ~we;
      wr          = ce & we;
      hit_own     = (addr == OWN_ADDR);
      hit_peer    = (addr == PEER_ADDR);
      evt.rd_own  = rd & hit_own;
      evt.rd_peer = rd & hit_peer;
      evt.wr_own  = wr & hit_own;
      evt.wr_peer = wr & hit_peer;
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    irq_n <= 1'b1;
      else if (set)  irq_n <= 1'b0;
      else if (clr)  irq_n <= 1'b1;
   end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_pri,
   input  logic [DATA_W-1:0] d_pri,
   input  logic              wr_sec,
   input  logic [DATA_W-1:0] d_sec,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wr_pri) q <= d_pri;
      else if (wr_sec) q <= d_sec;
   end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce,
   input  logic              l_oe,
   input  logic              l_we,
   input  logic              l_busy,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_irq_n,
   input  logic              r_ce,
   input  logic              r_oe,
   input  logic              r_we,
   input  logic              r_busy,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_irq_n
);
   import mbx_pkg::*;

   localparam logic [ADDR_W-1:0] BOX_RIGHT = '1;
   localparam logic [ADDR_W-1:0] BOX_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};

   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
      $error("mbx_irq_ctrl: ADDR_W must lie in 2..32");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("mbx_irq_ctrl: DATA_W must be at least 1");
   end

   logic [NPORT-1:0] ce_v, oe_v, we_v, busy_v, irq_v;
   logic [ADDR_W-1:0] addr_v  [NPORT];
   logic [DATA_W-1:0] wdata_v [NPORT];
   logic [DATA_W-1:0] rdata_v [NPORT];
   logic [DATA_W-1:0] box_q   [NPORT];
   port_evt_t         evt     [NPORT];

   assign ce_v   = {r_ce, l_ce};
   assign oe_v   = {r_oe, l_oe};
   assign we_v   = {r_we, l_we};
   assign busy_v = {r_busy, l_busy};
   assign addr_v[0]  = l_addr;
   assign addr_v[1]  = r_addr;
   assign wdata_v[0] = l_wdata;
   assign wdata_v[1] = r_wdata;

   for (genvar i = 0; i < NPORT; i++) begin : g_port
      localparam int PEER = NPORT - 1 - i;
      localparam logic [ADDR_W-1:0] OWN_A  = (i == 0) ? BOX_LEFT  : BOX_RIGHT;
      localparam logic [ADDR_W-1:0] PEER_A = (i == 0) ? BOX_RIGHT : BOX_LEFT;

      mbx_port_dec #(
         .ADDR_W   (ADDR_W),
         .OWN_ADDR (OWN_A),
         .PEER_ADDR(PEER_A)
      ) dec_i (
         .ce  (ce_v[i]),
         .oe  (oe_v[i]),
         .we  (we_v[i]),
         .addr(addr_v[i]),
         .evt (evt[i])
      );

      mbx_flag flag_i (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (evt[PEER].wr_peer & ~busy_v[PEER]),
         .clr  (evt[i].rd_own & ~busy_v[i]),
         .irq_n(irq_v[i])
      );

      mbx_store #(.DATA_W(DATA_W)) store_i (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_pri(evt[PEER].wr_peer),
         .d_pri (wdata_v[PEER]),
         .wr_sec(evt[i].wr_own),
         .d_sec (wdata_v[i]),
         .q     (box_q[i])
      );

      always_comb begin
         if (evt[i].rd_own)       rdata_v[i] = box_q[i];
         else if (evt[i].rd_peer) rdata_v[i] = box_q[PEER];
         else                     rdata_v[i] = '0;
      end
   end

   assign l_rdata = rdata_v[0];
   assign r_rdata = rdata_v[1];
   assign l_irq_n = irq_v[0];
   assign r_irq_n = irq_v[1];
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_ce,
   input logic              l_oe,
   input logic              l_we,
   input logic              l_busy,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_wdata,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_irq_n,
   input logic              r_ce,
   input logic              r_oe,
   input logic              r_we,
   input logic              r_busy,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_wdata,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_irq_n
);
   localparam logic [ADDR_W-1:0] TOP_A = '1;
   localparam logic [ADDR_W-1:0] SUB_A = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic l_rd, r_rd, set_r, set_l, clr_r, clr_l, l_box, r_box;
   logic unused_wd;

   assign unused_wd = ^{l_wdata, r_wdata};
   assign l_rd  = l_ce & l_oe & ~l_we;
   assign r_rd  = r_ce & r_oe & ~r_we;
   assign set_r = l_ce & l_we & (l_addr == TOP_A) & ~l_busy;
   assign set_l = r_ce & r_we & (r_addr == SUB_A) & ~r_busy;
   assign clr_r = r_rd & (r_addr == TOP_A) & ~r_busy;
   assign clr_l = l_rd & (l_addr == SUB_A) & ~l_busy;
   assign l_box = (l_addr == TOP_A) || (l_addr == SUB_A);
   assign r_box = (r_addr == TOP_A) || (r_addr == SUB_A);

   p_set_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_r |=> !r_irq_n);
   p_set_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_l |=> !l_irq_n);
   p_clear_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_r && !set_r) |=> r_irq_n);
   p_clear_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_l && !set_l) |=> l_irq_n);
   p_stay_high_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (r_irq_n && !set_r) |=> r_irq_n);
   p_stay_high_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (l_irq_n && !set_l) |=> l_irq_n);
   p_stay_low_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_irq_n && !clr_r) |=> !r_irq_n);
   p_stay_low_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_irq_n && !clr_l) |=> !l_irq_n);
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_r && clr_r) |=> !r_irq_n);
   p_same_box_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rd && r_rd && l_box && (l_addr == r_addr)) |-> (l_rdata == r_rdata));
   p_left_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_rd || !l_box) |-> (l_rdata == '0));
   p_right_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_rd || !r_box) |-> (r_rdata == '0));
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/mbx_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_tb_top;
   localparam int AW = 14;
   localparam int DW = 16;
   localparam logic [AW-1:0] TOP_A = 14'h3FFF;
   localparam logic [AW-1:0] SUB_A = 14'h3FFE;
   localparam logic [AW-1:0] PLAIN_A = 14'h0123;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_ce = 0, l_oe = 0, l_we = 0, l_busy = 0;
   logic r_ce = 0, r_oe = 0, r_we = 0, r_busy = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic l_irq_n, r_irq_n;

   // pending stimulus applied inside tick
   logic n_lce = 0, n_loe = 0, n_lwe = 0, n_lbusy = 0;
   logic n_rce = 0, n_roe = 0, n_rwe = 0, n_rbusy = 0;
   logic [AW-1:0] n_laddr = '0, n_raddr = '0;
   logic [DW-1:0] n_lwd = '0, n_rwd = '0;

   // expected state
   logic e_lirq = 1'b1, e_rirq = 1'b1;
   logic [DW-1:0] e_box_sub = '0, e_box_top = '0;

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   always #2.5 clk = ~clk;

   mbx_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_ce(l_ce), .l_oe(l_oe), .l_we(l_we), .l_busy(l_busy),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
      .r_ce(r_ce), .r_oe(r_oe), .r_we(r_we), .r_busy(r_busy),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
   );

   task automatic check(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic set_l(input logic ce, oe, we, busy, input logic [AW-1:0] a, input logic [DW-1:0] d);
      n_lce = ce; n_loe = oe; n_lwe = we; n_lbusy = busy; n_laddr = a; n_lwd = d;
   endtask

   task automatic set_r(input logic ce, oe, we, busy, input logic [AW-1:0] a, input logic [DW-1:0] d);
      n_rce = ce; n_roe = oe; n_rwe = we; n_rbusy = busy; n_raddr = a; n_rwd = d;
   endtask

   task automatic idle();
      set_l(0, 0, 0, 0, '0, '0);
      set_r(0, 0, 0, 0, '0, '0);
   endtask

   function automatic logic [DW-1:0] exp_rd(input logic ce, oe, we, input logic [AW-1:0] a);
      if (!(ce && oe && !we)) return '0;
      if (a == TOP_A) return e_box_top;
      if (a == SUB_A) return e_box_sub;
      return '0;
   endfunction

   task automatic tick();
      logic lrd, rrd, lwr, rwr, s_r, s_l, c_r, c_l;
      @(negedge clk);
      check("l_irq_n", {{(DW-1){1'b0}}, l_irq_n}, {{(DW-1){1'b0}}, e_lirq});
      check("r_irq_n", {{(DW-1){1'b0}}, r_irq_n}, {{(DW-1){1'b0}}, e_rirq});
      l_ce = n_lce; l_oe = n_loe; l_we = n_lwe; l_busy = n_lbusy; l_addr = n_laddr; l_wdata = n_lwd;
      r_ce = n_rce; r_oe = n_roe; r_we = n_rwe; r_busy = n_rbusy; r_addr = n_raddr; r_wdata = n_rwd;
      #1;
      check("l_rdata", l_rdata, exp_rd(l_ce, l_oe, l_we, l_addr));
      check("r_rdata", r_rdata, exp_rd(r_ce, r_oe, r_we, r_addr));
      lrd = l_ce & l_oe & ~l_we;  rrd = r_ce & r_oe & ~r_we;
      lwr = l_ce & l_we;          rwr = r_ce & r_we;
      s_r = lwr && l_addr == TOP_A && !l_busy;
      s_l = rwr && r_addr == SUB_A && !r_busy;
      c_r = rrd && r_addr == TOP_A && !r_busy;
      c_l = lrd && l_addr == SUB_A && !l_busy;
      if (s_r) e_rirq = 1'b0; else if (c_r) e_rirq = 1'b1;
      if (s_l) e_lirq = 1'b0; else if (c_l) e_lirq = 1'b1;
      if (lwr && l_addr == TOP_A)      e_box_top = l_wdata;
      else if (rwr && r_addr == TOP_A) e_box_top = r_wdata;
      if (rwr && r_addr == SUB_A)      e_box_sub = r_wdata;
      else if (lwr && l_addr == SUB_A) e_box_sub = l_wdata;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state, reading mailboxes while reset is held
      tag = "R1";
      repeat (2) @(negedge clk);
      l_ce = 1; l_oe = 1; l_addr = SUB_A;
      r_ce = 1; r_oe = 1; r_addr = TOP_A;
      #1;
      check("l_rdata in reset", l_rdata, '0);
      check("r_rdata in reset", r_rdata, '0);
      check("l_irq_n in reset", {{(DW-1){1'b0}}, l_irq_n}, 16'd1);
      check("r_irq_n in reset", {{(DW-1){1'b0}}, r_irq_n}, 16'd1);
      @(negedge clk);
      rst_n = 1'b1;
      set_l(1, 1, 0, 0, TOP_A, '0);
      set_r(1, 1, 0, 0, SUB_A, '0);
      tick();

      // R2: each port raises the other's flag
      tag = "R2";
      idle(); set_l(1, 0, 1, 0, TOP_A, 16'hA5A5); tick();
      idle(); set_r(1, 0, 1, 0, SUB_A, 16'h5A5A); tick();
      idle(); tick();

      // R4: peer mailbox reads leave flags alone
      tag = "R4";
      set_l(1, 1, 0, 0, TOP_A, '0); set_r(1, 1, 0, 0, SUB_A, '0); tick();
      idle(); tick();

      // R6: busy owner read cannot release
      tag = "R6";
      set_r(1, 1, 0, 1, TOP_A, '0); set_l(1, 1, 0, 1, SUB_A, '0); tick();
      idle(); tick();

      // R3: owner reads release
      tag = "R3";
      set_r(1, 1, 0, 0, TOP_A, '0); tick();
      idle(); set_l(1, 1, 0, 0, SUB_A, '0); tick();
      idle(); tick();

      // R5: busy writer cannot raise, data still lands
      tag = "R5";
      set_l(1, 0, 1, 1, TOP_A, 16'h1357); set_r(1, 0, 1, 1, SUB_A, 16'h2468); tick();
      idle(); set_r(1, 1, 0, 0, TOP_A, '0); set_l(1, 1, 0, 0, SUB_A, '0); tick();
      idle(); tick();

      // R7: set and clear collide, set wins
      tag = "R7";
      set_l(1, 0, 1, 0, TOP_A, 16'h0F0F); set_r(1, 1, 0, 0, TOP_A, '0); tick();
      idle(); tick();

      // R10: own-mailbox writes store data only
      tag = "R10";
      set_r(1, 0, 1, 0, TOP_A, 16'hC0DE); set_l(1, 0, 1, 0, SUB_A, 16'hBEEF); tick();
      idle(); set_l(1, 1, 0, 0, TOP_A, '0); set_r(1, 1, 0, 0, SUB_A, '0); tick();

      // R8: both ports write the same mailbox, non-owner kept
      tag = "R8";
      set_l(1, 0, 1, 0, TOP_A, 16'h1111); set_r(1, 0, 1, 0, TOP_A, 16'h2222); tick();
      idle(); set_l(1, 1, 0, 0, TOP_A, '0); set_r(1, 1, 0, 0, TOP_A, '0); tick();

      // R9: non-mailbox and non-read accesses
      tag = "R9";
      set_l(1, 1, 0, 0, PLAIN_A, '0); set_r(1, 1, 1, 0, TOP_A, 16'h3333); tick();
      set_l(0, 1, 0, 0, SUB_A, '0);   set_r(1, 0, 1, 0, PLAIN_A, 16'h4444); tick();
      idle(); tick();

      // sweep: all control, busy and address-class pairs on both ports
      tag = "R2/R3/R5/R6/R7/R8/R9";
      for (int lv = 0; lv < 48; lv++) begin
         for (int rv = 0; rv < 48; rv++) begin
            logic [AW-1:0] la, ra;
            la = (lv / 16 == 0) ? SUB_A : (lv / 16 == 1) ? TOP_A : PLAIN_A;
            ra = (rv / 16 == 0) ? TOP_A : (rv / 16 == 1) ? SUB_A : PLAIN_A;
            set_l(lv[0], lv[1], lv[2], lv[3], la, DW'(lv * 97 + rv));
            set_r(rv[0], rv[1], rv[2], rv[3], ra, DW'(rv * 131 + lv + 16'h8000));
            tick();
         end
      end
      idle(); tick(); tick();
      finish_run();
   end
endmodule